// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Bypass Control

This block is the hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction waiting in decode with the destination registers of the two older instructions ahead of it: the one in execute and the one in the memory stage. From this comparison it chooses where each ALU operand of the next execute-stage instruction should come from. It also decides whether decode has to wait for a load. Once the pipeline is full, one instruction retires per cycle after a four-cycle fill, and this controller is what keeps dependent instructions correct without giving up that rate in the common case.

Two kinds of stall are produced. A load-use interlock holds the program counter and the fetch/decode latch and turns the decode/execute latch into a no-op. This happens when the instruction directly behind a load needs the loaded value, and it costs exactly one cycle. A structural stall holds only the program counter while the memory stage uses the single memory that is shared between instructions and data. Decode still advances, and the fetch/decode latch is loaded with a no-op because no instruction was fetched.

The bypass selects are registered. The choice is made while the consumer sits in decode and is stored at the same clock edge that moves the consumer into execute. The operand multiplexers therefore see a flop output rather than a comparator tree.

Top module: `hzc_ctrl`

## Requirements
- R1: A synchronous active-high reset forces both bypass selects to 2'b00 (register file), and reset takes priority over any register match.
- R2: If the execute-stage instruction writes a non-zero register that a decode source reads, and it is not a load, then no stall is raised and that operand's select becomes 2'b10 (execute/memory latch) on the next cycle.
- R3: If only the memory-stage instruction writes a non-zero register that a decode source reads, that operand's select becomes 2'b01 (memory/writeback latch) on the next cycle, with no stall.
- R4: If the execute-stage and memory-stage instructions both write the register that a source reads, the younger producer wins and the select becomes 2'b10.
- R5: If a load in execute writes a non-zero register that either decode source reads, then in that same cycle pc_hold, ifid_hold and idex_bubble are all 1 and ifid_kill is 0, and on the next cycle both selects are 2'b00 (bubble).
- R6: After the single load-use stall, the load sits in the memory stage while using memory. The consumer then advances with select 2'b01 and ifid_hold is 0, so the load costs exactly one stall cycle.
- R7: When mem_access is 1 and there is no load-use hazard, pc_hold and ifid_kill are 1 while ifid_hold and idex_bubble are 0, and the bypass selects follow R2 to R4.
- R8: When a load-use hazard and mem_access occur in the same cycle, pc_hold, ifid_hold and idex_bubble are 1 and ifid_kill is 0.
- R9: Register 0 never causes forwarding or a stall, even when a producer names it as its destination.
- R10: A producer whose write enable is 0 never causes forwarding or a stall, even when it is a load.
- R11: A load in execute whose destination matches neither decode source raises no stall.
- R12: A bypass select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Register write enable of the instruction in execute |
| ex_load | input | 1 | The instruction in execute is a load |
| mem_rd | input | AW | Destination register of the instruction in the memory stage |
| mem_wen | input | 1 | Register write enable of the instruction in the memory stage |
| mem_access | input | 1 | The memory-stage instruction uses the shared memory this cycle |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode latch unchanged |
| ifid_kill | output | 1 | Load a no-op into the fetch/decode latch |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |
| fwd_a_sel | output | 2 | Operand A source for the execute stage: 00 register file, 01 memory/writeback latch, 10 execute/memory latch |
| fwd_b_sel | output | 2 | Operand B source, same encoding |

## Verification
The bench targets priority when both latches name the same register. A design that got this wrong would deliver the older value and pass stale data. It checks register 0 and producers with their write enable cleared. A wrong design would forward garbage or stall with no need. It runs the load followed by its consumer in back-to-back cycles. A design that stalls twice, or that stalls on the structural hazard while the load is in the memory stage, would lose a cycle or fail to hand over the 2'b01 select. It also raises both stalls together. A design that killed the fetch/decode latch in that case would throw away the held consumer instruction.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE   = 2'b00,
    SEL_WB_LATCH  = 2'b01,
    SEL_MEM_LATCH = 2'b10
  } byp_sel_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hzc_match.sv
module hzc_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  output logic          hit_ex,
  output logic          hit_mem
);

  logic src_live;

  always_comb begin
    src_live = (src != '0);
    hit_ex   = src_live && ex_wen  && (ex_rd  == src);
    hit_mem  = src_live && mem_wen && (mem_rd == src);
  end

endmodule

// File: rtl/hzc_byp_pick.sv
module hzc_byp_pick
  import hzc_pkg::*;
(
  input  logic     hit_ex,
  input  logic     hit_mem,
  input  logic     bubble,
  output byp_sel_e sel_nxt
);

  always_comb begin
    if (bubble)       sel_nxt = SEL_REGFILE;
    else if (hit_ex)  sel_nxt = SEL_MEM_LATCH;
    else if (hit_mem) sel_nxt = SEL_WB_LATCH;
    else              sel_nxt = SEL_REGFILE;
  end

endmodule

// File: rtl/hzc_stall.sv
module hzc_stall #(
  parameter int unsigned NS = 2
) (
  input  logic [NS-1:0] hit_ex,
  input  logic          ex_load,
  input  logic          mem_access,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_kill,
  output logic          idex_bubble
);

  logic load_use;

  always_comb begin
    load_use    = ex_load && (|hit_ex);
    pc_hold     = load_use || mem_access;
    ifid_hold   = load_use;
    ifid_kill   = mem_access && !load_use;
    idex_bubble = load_use;
  end

endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_access,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_kill,
  output logic          idex_bubble,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel
);

  localparam int unsigned NS = NUM_SRC;

  logic [AW-1:0] src_v [NS];
  logic [NS-1:0] hit_ex_v;
  logic [NS-1:0] hit_mem_v;
  byp_sel_e      sel_nxt [NS];
  logic [1:0]    sel_q   [NS];
  logic          bubble_w;

  assign src_v[0] = id_rs1;
  assign src_v[1] = id_rs2;

  generate
    for (genvar s = 0; s < NS; s++) begin : g_src
      hzc_match #(.AW(AW)) u_match (
        .src     (src_v[s]),
        .ex_rd   (ex_rd),
        .ex_wen  (ex_wen),
        .mem_rd  (mem_rd),
        .mem_wen (mem_wen),
        .hit_ex  (hit_ex_v[s]),
        .hit_mem (hit_mem_v[s])
      );

      hzc_byp_pick u_pick (
        .hit_ex  (hit_ex_v[s]),
        .hit_mem (hit_mem_v[s]),
        .bubble  (bubble_w),
        .sel_nxt (sel_nxt[s])
      );

      always_ff @(posedge clk) begin
        if (rst) sel_q[s] <= SEL_REGFILE;
        else     sel_q[s] <= sel_nxt[s];
      end
    end
  endgenerate

  hzc_stall #(.NS(NS)) u_stall (
    .hit_ex      (hit_ex_v),
    .ex_load     (ex_load),
    .mem_access  (mem_access),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_kill   (ifid_kill),
    .idex_bubble (bubble_w)
  );

  assign idex_bubble = bubble_w;
  assign fwd_a_sel   = sel_q[0];
  assign fwd_b_sel   = sel_q[1];

endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_access,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_kill,
  input logic          idex_bubble,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel
);

  assert_rst_sel_R1: assert property (@(posedge clk)
    rst |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  assert_young_first_R4: assert property (@(posedge clk) disable iff (rst)
    (!idex_bubble && ex_wen && ex_rd != '0 && ex_rd == id_rs1)
      |=> fwd_a_sel == 2'b10);

  assert_bubble_sel_R5: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  assert_hold_group_R5: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |-> (pc_hold && idex_bubble));

  assert_kill_xor_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ifid_hold, ifid_kill}));

  assert_kill_pc_R7: assert property (@(posedge clk) disable iff (rst)
    ifid_kill |-> (pc_hold && !idex_bubble));

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && id_rs2 == '0) |-> !idex_bubble ##1
      (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  assert_no_wen_R10: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen) |-> !idex_bubble);

  assert_enc_R12: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11));

endmodule

bind hzc_ctrl hzc_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/hzc_ctrl_tb.sv
module hzc_ctrl_tb;

  localparam int unsigned AW = 5;
  localparam int NV = 11;

  typedef struct packed {
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] erd;
    logic       ewen;
    logic       eld;
    logic [4:0] mrd;
    logic       mwen;
    logic       macc;
    logic       x_pc;
    logic       x_hold;
    logic       x_kill;
    logic       x_bub;
    logic [1:0] x_a;
    logic [1:0] x_b;
  } vec_t;

  // fields: rs1 rs2 erd ewen eld mrd mwen macc | pc hold kill bub a b
  localparam vec_t VEC [NV] = '{
    '{5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b00}, // R2
    '{5'd5,  5'd6,  5'd7,  1'b1, 1'b0, 5'd6,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01}, // R3
    '{5'd8,  5'd8,  5'd8,  1'b1, 1'b0, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10}, // R4
    '{5'd9,  5'd2,  5'd9,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}, // R5
    '{5'd9,  5'd2,  5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00}, // R6
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00}, // R9
    '{5'd4,  5'd4,  5'd4,  1'b0, 1'b1, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00}, // R10
    '{5'd11, 5'd12, 5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00}, // R11
    '{5'd1,  5'd14, 5'd14, 1'b1, 1'b1, 5'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}, // R8
    '{5'd15, 5'd16, 5'd15, 1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 2'b01}, // R7
    '{5'd2,  5'd31, 5'd31, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}  // R5
  };

  string tags [NV] = '{"R2", "R3", "R4", "R5", "R6", "R9", "R10", "R11", "R8", "R7", "R5"};

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic          ex_wen, ex_load, mem_wen, mem_access;
  logic          pc_hold, ifid_hold, ifid_kill, idex_bubble;
  logic [1:0]    fwd_a_sel, fwd_b_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hzc_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_access(mem_access),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_kill(ifid_kill),
    .idex_bubble(idex_bubble), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel)
  );

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_rs1 = v.rs1; id_rs2 = v.rs2;
    ex_rd = v.erd; ex_wen = v.ewen; ex_load = v.eld;
    mem_rd = v.mrd; mem_wen = v.mwen; mem_access = v.macc;
  endtask

  initial begin
    rst = 1'b1;
    drive('{5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00});
    @(posedge clk); @(posedge clk); #1;
    // R1: reset wins over a live match
    chk("R1", "fwd_a_sel in reset", fwd_a_sel, 2'b00);
    chk("R1", "fwd_b_sel in reset", fwd_b_sel, 2'b00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      #1;
      chk(tags[i], "pc_hold",     {1'b0, pc_hold},     {1'b0, VEC[i].x_pc});
      chk(tags[i], "ifid_hold",   {1'b0, ifid_hold},   {1'b0, VEC[i].x_hold});
      chk(tags[i], "ifid_kill",   {1'b0, ifid_kill},   {1'b0, VEC[i].x_kill});
      chk(tags[i], "idex_bubble", {1'b0, idex_bubble}, {1'b0, VEC[i].x_bub});
      @(posedge clk); #1;
      chk(tags[i], "fwd_a_sel", fwd_a_sel, VEC[i].x_a);
      chk(tags[i], "fwd_b_sel", fwd_b_sel, VEC[i].x_b);
      // R12: encoding 11 never appears
      chk("R12", "fwd_a_sel not 11", {1'b0, fwd_a_sel == 2'b11}, 2'b00);
      @(negedge clk);
    end

    // R1: reset mid-run clears a select that was 10
    drive(VEC[2]);
    @(posedge clk); #1;
    chk("R4", "select before reset", fwd_a_sel, 2'b10);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "fwd_a_sel after sync reset", fwd_a_sel, 2'b00);
    chk("R1", "fwd_b_sel after sync reset", fwd_b_sel, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule